// File: doc/BRIEF.md
# Message-Signalled Interrupt Write Generator

This block sits between a device's interrupt sources and its outbound posted-write path. Each vector has a request input. A pulse on that input marks the vector pending. The block then picks the most urgent pending vector that is enabled and unmasked. For that vector it issues exactly one memory write: the address is the programmed target, and the data word is the programmed base value with the vector number placed in its low bits. The host's interrupt controller decodes that word to find the vector.

The device's ordinary DMA writes pass through the same block to reach the shared write port. A message starts only when no DMA write is waiting. A message that is already on the port holds the port until the sink takes it. As a result, an interrupt write can never overtake a DMA write that the device presented before it.

A narrow register write port sets up the block. Through it, software programs the target address, the base data word, a global enable and the enabled vector count. Two features are optional and chosen by parameter: 64-bit addressing and per-vector masking.

Top module: `msi_msg_gen`

## Requirements
- R1: Configuration writes go through `cfg_we`/`cfg_sel`/`cfg_wdata`. Select 0 writes address bits 31:0. Select 1 writes address bits 63:32. Select 2 writes the 16-bit base data from `cfg_wdata[15:0]`. Select 3 writes the control register: bit 0 is the enable and bits 6:4 are log2 of the enabled vector count. A count code above log2(NUM_VEC) is clamped to log2(NUM_VEC). Select 4 writes the mask, one bit per vector, where bit k masks vector k.
- R2: Every vector is served by one write to the single programmed address. Requests that repeat while the vector is still pending merge into a single message.
- R3: The message for vector k has a data word equal to the base data with its low log2(count) bits replaced by k. The upper bits of the base pass through unchanged. The word is zero-extended to the port width.
- R4: A request on a vector numbered at or above the enabled count marks the highest enabled vector (count-1) pending.
- R5: While the enable bit is 0, no message is issued. Pending vectors are kept and are sent once the enable is set.
- R6: Pending vectors are sent in fixed priority, lowest vector number first.
- R7: A presented message keeps its address and data stable while `wr_ready` is low. Its pending bit clears only when `wr_valid` and `wr_ready` are both high.
- R8: A message is launched only in a cycle where `dma_valid` is low. While a message is presented, `dma_ready` stays low and the port carries the message. Otherwise DMA writes pass to the port unchanged.
- R9: A masked vector stays pending and sends nothing. Once it is unmasked, its message is sent.
- R10: After reset, `wr_valid` is low and the address, base data, enable, count code and mask all read as zero. The effect of these zeroes is seen in the first message.
- R11: With 64-bit addressing built, the message address is the full 64-bit value from selects 1 and 0. Without it, the upper 32 bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| irq_req | input | NUM_VEC | Per-vector interrupt request pulses |
| dma_valid | input | 1 | DMA write request valid |
| dma_ready | output | 1 | DMA write accepted when high with dma_valid |
| dma_addr | input | 64 | DMA write address |
| dma_data | input | DATA_W | DMA write data |
| wr_valid | output | 1 | Outbound write valid |
| wr_ready | input | 1 | Outbound sink ready |
| wr_addr | output | 64 | Outbound write address |
| wr_data | output | DATA_W | Outbound write data |

## Verification
The bench builds the block with eight vectors, 64-bit addressing and masking turned on. The vector space is small enough to sweep every vector under each count code from one to eight, which covers both in-range data forming and folding. The 64-bit address brings the high register into every expected address. Masking lets the bench check hold-and-release. Scenarios driven one at a time check the priority order, merging of repeated requests, back-pressure, and the ordering of DMA and message writes in both directions.

// File: rtl/msi_gen_pkg.sv
package msi_gen_pkg;
   localparam logic [2:0] SEL_ADDR_LO = 3'd0;
   localparam logic [2:0] SEL_ADDR_HI = 3'd1;
   localparam logic [2:0] SEL_BASE    = 3'd2;
   localparam logic [2:0] SEL_CTRL    = 3'd3;
   localparam logic [2:0] SEL_MASK    = 3'd4;
   localparam int         MSG_W       = 16;
   localparam int         VEC_LIMIT   = 32;

   // base word with its low 'lg' bits taken from the vector number
   function automatic logic [MSG_W-1:0] form_data(input logic [MSG_W-1:0] base,
                                                  input logic [4:0] vec,
                                                  input logic [2:0] lg);
      logic [MSG_W-1:0] low;
      low = (MSG_W'(1) << lg) - MSG_W'(1);
      return (base & ~low) | ({11'b0, vec} & low);
   endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs
   import msi_gen_pkg::*;
#(
   parameter int NUM_VEC  = 32,
   parameter bit HAS_MASK = 1'b1,
   parameter bit ADDR64   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [2:0]         sel,
   input  logic [31:0]        wdata,
   output logic [63:0]        tgt_addr,
   output logic [MSG_W-1:0]   base,
   output logic               en,
   output logic [2:0]         lg,
   output logic [NUM_VEC-1:0] mask
);
   localparam int          LG_MAX = $clog2(NUM_VEC);
   localparam logic [2:0]  LG_TOP = 3'(LG_MAX);

   logic [31:0] addr_lo;
   logic [31:0] addr_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_lo <= '0;
         base    <= '0;
         en      <= 1'b0;
         lg      <= '0;
      end else if (we) begin
         case (sel)
            SEL_ADDR_LO: addr_lo <= wdata;
            SEL_BASE:    base    <= wdata[MSG_W-1:0];
            SEL_CTRL: begin
               en <= wdata[0];
               lg <= (wdata[6:4] > LG_TOP) ? LG_TOP : wdata[6:4];
            end
            default: ;
         endcase
      end
   end

   generate
      if (ADDR64) begin : g_hi
         always_ff @(posedge clk) begin
            if (!rst_n)                         addr_hi <= '0;
            else if (we && sel == SEL_ADDR_HI)  addr_hi <= wdata;
         end
      end else begin : g_nohi
         assign addr_hi = '0;
      end

      if (HAS_MASK) begin : g_mask
         always_ff @(posedge clk) begin
            if (!rst_n)                      mask <= '0;
            else if (we && sel == SEL_MASK)  mask <= wdata[NUM_VEC-1:0];
         end
      end else begin : g_nomask
         assign mask = '0;
      end
   endgenerate

   assign tgt_addr = {addr_hi, addr_lo};
endmodule

// File: rtl/msi_pend.sv
module msi_pend #(
   parameter int NUM_VEC = 32,
   localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] req,
   input  logic [2:0]         lg,
   input  logic               clr,
   input  logic [VW-1:0]      clr_idx,
   output logic [NUM_VEC-1:0] in_rng,
   output logic [NUM_VEC-1:0] pend
);
   logic [NUM_VEC-1:0] top_sel;
   logic [NUM_VEC-1:0] clr_vec;
   logic [NUM_VEC-1:0] set_vec;
   logic               fold_hit;

   generate
      for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
         assign in_rng[i]  = ((32'(i) >> lg) == 32'd0);
         assign top_sel[i] = in_rng[i] && (((32'(i) + 32'd1) >> lg) != 32'd0);
         assign clr_vec[i] = clr && (clr_idx == VW'(i));

         // R7: a pending bit drops only on the cycle its message is taken
         assert_clear_on_accept_R7 : assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pend[i]) |-> $past(clr && clr_idx == VW'(i)));
      end
   endgenerate

   assign fold_hit = |(req & ~in_rng);
   assign set_vec  = (req & in_rng) | ({NUM_VEC{fold_hit}} & top_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/msi_pick.sv
module msi_pick #(
   parameter int NUM_VEC = 32,
   localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic [NUM_VEC-1:0] elig,
   output logic               any,
   output logic [VW-1:0]      idx
);
   always_comb begin
      idx = '0;
      for (int i = NUM_VEC - 1; i >= 0; i--) begin
         if (elig[i]) idx = VW'(i);
      end
   end
   assign any = |elig;
endmodule

// File: rtl/msi_msg_gen.sv
module msi_msg_gen
   import msi_gen_pkg::*;
#(
   parameter int NUM_VEC  = 32,
   parameter bit HAS_MASK = 1'b1,
   parameter bit ADDR64   = 1'b1,
   parameter int DATA_W   = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [2:0]         cfg_sel,
   input  logic [31:0]        cfg_wdata,
   input  logic [NUM_VEC-1:0] irq_req,
   input  logic               dma_valid,
   output logic               dma_ready,
   input  logic [63:0]        dma_addr,
   input  logic [DATA_W-1:0]  dma_data,
   output logic               wr_valid,
   input  logic               wr_ready,
   output logic [63:0]        wr_addr,
   output logic [DATA_W-1:0]  wr_data
);
   localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

   generate
      if (NUM_VEC < 1 || NUM_VEC > VEC_LIMIT || (NUM_VEC & (NUM_VEC - 1)) != 0) begin : g_bad_nv
         $error("NUM_VEC must be a power of two from 1 to 32");
      end
      if (DATA_W <= MSG_W) begin : g_bad_dw
         $error("DATA_W must be wider than the message word");
      end
   endgenerate

   logic [63:0]        tgt_addr;
   logic [MSG_W-1:0]   base;
   logic               en;
   logic [2:0]         lg;
   logic [NUM_VEC-1:0] mask;
   logic [NUM_VEC-1:0] in_rng;
   logic [NUM_VEC-1:0] pend;
   logic               any;
   logic [VW-1:0]      idx;
   logic               launch;
   logic               busy;
   logic               accept;
   logic [VW-1:0]      msg_idx;
   logic [63:0]        msg_addr;
   logic [MSG_W-1:0]   msg_data;

   msi_cfg_regs #(.NUM_VEC(NUM_VEC), .HAS_MASK(HAS_MASK), .ADDR64(ADDR64)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .tgt_addr(tgt_addr), .base(base), .en(en), .lg(lg), .mask(mask));

   msi_pend #(.NUM_VEC(NUM_VEC)) u_pend (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .lg(lg), .clr(accept),
      .clr_idx(msg_idx), .in_rng(in_rng), .pend(pend));

   msi_pick #(.NUM_VEC(NUM_VEC)) u_pick (
      .elig(pend & in_rng & ~mask), .any(any), .idx(idx));

   assign accept = busy && wr_ready;
   assign launch = en && any && !busy && !dma_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         msg_idx  <= '0;
         msg_addr <= '0;
         msg_data <= '0;
      end else if (launch) begin
         busy     <= 1'b1;
         msg_idx  <= idx;
         msg_addr <= tgt_addr;
         msg_data <= form_data(base, 5'(idx), lg);
      end else if (accept) begin
         busy     <= 1'b0;
      end
   end

   assign wr_valid  = busy || dma_valid;
   assign wr_addr   = busy ? msg_addr : dma_addr;
   assign wr_data   = busy ? {{(DATA_W-MSG_W){1'b0}}, msg_data} : dma_data;
   assign dma_ready = wr_ready && !busy;

   assert_hold_stable_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      busy && !wr_ready |=> busy && $stable(wr_addr) && $stable(wr_data));

   assert_no_send_disabled_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(en));

   assert_dma_first_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(dma_valid));

   assert_unmasked_only_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> !mask[idx]);
endmodule

// File: tb/msi_msg_gen_test.sv
module msi_msg_gen_test;
   localparam int NV = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_sel = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [NV-1:0] irq_req = '0;
   logic          dma_valid = 1'b0;
   logic          dma_ready;
   logic [63:0]   dma_addr = '0;
   logic [31:0]   dma_data = '0;
   logic          wr_valid;
   logic          wr_ready = 1'b1;
   logic [63:0]   wr_addr;
   logic [31:0]   wr_data;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [63:0] qa[$];
   logic [31:0] qd[$];

   always #4 clk = ~clk;

   msi_msg_gen #(.NUM_VEC(NV), .HAS_MASK(1'b1), .ADDR64(1'b1), .DATA_W(32)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .irq_req(irq_req), .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
      .dma_data(dma_data), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
      .wr_data(wr_data));

   always @(posedge clk) begin
      if (rst_n && wr_valid && wr_ready) begin
         qa.push_back(wr_addr);
         qd.push_back(wr_data);
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input logic [NV-1:0] m);
      @(negedge clk);
      irq_req = m;
      @(negedge clk);
      irq_req = '0;
   endtask

   task automatic expect_write(input string tag, input logic [63:0] ea, input logic [31:0] ed);
      int n = 0;
      while (qa.size() == 0 && n < 40) begin
         @(negedge clk);
         n++;
      end
      if (qa.size() == 0) begin
         check(1'b0, {tag, " no write"}, 64'd0, ea);
      end else begin
         logic [63:0] a;
         logic [31:0] d;
         a = qa.pop_front();
         d = qd.pop_front();
         check(a == ea, {tag, " addr"}, a, ea);
         check(d == ed, {tag, " data"}, {32'd0, d}, {32'd0, ed});
      end
   endtask

   task automatic expect_none(input string tag, input int cyc);
      repeat (cyc) @(negedge clk);
      check(qa.size() == 0, tag, 64'(qa.size()), 64'd0);
   endtask

   localparam logic [63:0] ADDR   = 64'h0000_0001_FEE0_1000;
   localparam logic [15:0] BASE   = 16'hABCD;

   function automatic logic [31:0] exp_data(input int v, input int lg);
      int cnt;
      int k;
      cnt = 1 << lg;
      k = (v < cnt) ? v : cnt - 1;
      return {16'd0, (BASE & ~16'(cnt - 1)) | 16'(k)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(wr_valid == 1'b0, "R10 wr_valid after reset", 64'(wr_valid), 64'd0);
      rst_n = 1'b1;
      cfg(3'd3, 32'h1);
      pulse(8'h01);
      expect_write("R10 zeroed registers", 64'd0, 32'd0);

      // R1 R11: program 64-bit address and base
      cfg(3'd0, ADDR[31:0]);
      cfg(3'd1, ADDR[63:32]);
      cfg(3'd2, {16'd0, BASE});

      // R3 R4: sweep every count code and vector
      for (int lg = 0; lg < 4; lg++) begin
         cfg(3'd3, 32'(1 | (lg << 4)));
         for (int v = 0; v < NV; v++) begin
            pulse(8'(1 << v));
            expect_write((v < (1 << lg)) ? "R3 data forming R11" : "R4 fold above count",
                         ADDR, exp_data(v, lg));
         end
      end

      // R1: count code above limit clamps to 3 (eight vectors)
      cfg(3'd3, 32'h61);
      pulse(8'h80);
      expect_write("R1 count clamp", ADDR, exp_data(7, 3));

      // R5 R6 R2: disabled hold, then priority order, repeats merged
      cfg(3'd3, 32'h30);
      pulse(8'b1011_0110);
      pulse(8'b0000_0100);
      expect_none("R5 nothing while disabled", 10);
      cfg(3'd3, 32'h31);
      expect_write("R6 order 1", ADDR, exp_data(1, 3));
      expect_write("R6 order 2", ADDR, exp_data(2, 3));
      expect_write("R6 order 4", ADDR, exp_data(4, 3));
      expect_write("R6 order 5", ADDR, exp_data(5, 3));
      expect_write("R6 order 7", ADDR, exp_data(7, 3));
      expect_none("R2 repeats merged", 10);

      // R7: back-pressure holds the message
      @(negedge clk);
      wr_ready = 1'b0;
      pulse(8'h08);
      repeat (3) @(negedge clk);
      check(wr_valid == 1'b1, "R7 valid under stall", 64'(wr_valid), 64'd1);
      check(wr_data == exp_data(3, 3), "R7 data under stall", {32'd0, wr_data}, {32'd0, exp_data(3, 3)});
      repeat (4) @(negedge clk);
      check(wr_valid == 1'b1 && wr_addr == ADDR, "R7 held after stall", wr_addr, ADDR);
      check(wr_data == exp_data(3, 3), "R7 data still held", {32'd0, wr_data}, {32'd0, exp_data(3, 3)});
      wr_ready = 1'b1;
      expect_write("R7 released", ADDR, exp_data(3, 3));
      expect_none("R7 single message", 8);

      // R9: masking holds and then releases
      cfg(3'd4, 32'h04);
      pulse(8'b0010_0100);
      expect_write("R9 unmasked goes", ADDR, exp_data(5, 3));
      expect_none("R9 masked held", 8);
      cfg(3'd4, 32'h00);
      expect_write("R9 sent after unmask", ADDR, exp_data(2, 3));

      // R8: earlier DMA write goes first
      @(negedge clk);
      wr_ready = 1'b0;
      dma_valid = 1'b1; dma_addr = 64'h2000; dma_data = 32'h1234_5678;
      pulse(8'h01);
      repeat (3) @(negedge clk);
      check(wr_addr == 64'h2000, "R8 DMA stays in front", wr_addr, 64'h2000);
      wr_ready = 1'b1;
      @(negedge clk);
      dma_valid = 1'b0;
      expect_write("R8 DMA first", 64'h2000, 32'h1234_5678);
      expect_write("R8 message after DMA", ADDR, exp_data(0, 3));

      // R8: a presented message blocks later DMA
      @(negedge clk);
      wr_ready = 1'b0;
      pulse(8'h02);
      repeat (3) @(negedge clk);
      dma_valid = 1'b1; dma_addr = 64'h3000; dma_data = 32'hCAFE_0001;
      @(negedge clk);
      check(dma_ready == 1'b0, "R8 DMA held behind message", 64'(dma_ready), 64'd0);
      check(wr_addr == ADDR, "R8 port carries message", wr_addr, ADDR);
      wr_ready = 1'b1;
      @(negedge clk);
      @(negedge clk);
      dma_valid = 1'b0;
      expect_write("R8 message first", ADDR, exp_data(1, 3));
      expect_write("R8 DMA passes after", 64'h3000, 32'hCAFE_0001);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule